// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block gathers single-cycle event pulses from several producers into a byte of sticky interrupt flags and a parameterised word of extended flags. Each flag stays set until the host interface reports the specific access that consumes it. Examples are a bulk data read command, a status register read, a frame-information read, or a request read. Per-source enable registers then decide which pending flags may pull the shared active-low interrupt pin.

The same pin also signals that the command engine is waiting for the payload transaction of a two-step command. The host interface pulses a completion strobe at the end of every successful transaction. That strobe forces the pin high for one cycle, so a condition that is still pending produces a fresh falling edge. Bit 6 of the flag byte is not stored. It is the OR of the extended flags, each gated by its own extended enable bit. Bit 7 shows the live busy indication of the host interface.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all flags, both enable registers and the extended flags clear to zero, and `irq_n_o` is high after that edge.
- R2: Each event pulse sets its flag at the next clock edge, whatever the enable bits hold. The flag stays set until its clear strobe. The flag byte bit positions are: 0 frame received, 1 stream lost, 2 window data changed, 3 link change, 4 alternate start code frame, 5 identify change, 6 extended aggregate, 7 busy.
- R3: Bit 2 is set only when `frame_done_i` and `win_diff_i` are high in the same cycle. `win_diff_i` alone sets nothing. `frame_done_i` alone sets only bit 0.
- R4: `clr_data_rd_i` clears bits 0 and 2. `clr_status_rd_i` clears bits 1, 3 and 5. `clr_info_rd_i` clears bit 4. No strobe touches any other bit.
- R5: When an event and a strobe that clears the same flag arrive in the same cycle, the flag is set after the edge.
- R6: A write to the primary enable register stores bits 0 to 6, and bit 7 always reads 0. A write to the extended enable register stores every bit. Without a write, both registers hold their value.
- R7: `flags_o[6]` equals the OR over all bits of `ext_flags_o & ext_mask_o` in the same cycle.
- R8: Extended flag bit 0 (request available) clears on `clr_req_rd_i` or `req_timeout_i`. The other extended bits clear on `clr_ext_rd_i`, which leaves bit 0 alone. An event on the same cycle wins.
- R9: `flags_o[7]` follows `busy_i` in the same cycle and never drives the pin.
- R10: One cycle after a cycle without `xfer_done_i`, `irq_n_o` is low if any of `flags_o[6:0] & mask_o[6:0]` is set or `payload_rdy_i` is high. Otherwise it is high.
- R11: The cycle after `xfer_done_i` is high, `irq_n_o` is high whatever is pending. In the following cycle the pin re-evaluates as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done_i | input | 1 | Complete data frame received pulse |
| win_diff_i | input | 1 | A slot inside the window differs from the previous frame |
| lost_evt_i | input | 1 | Data stream lost pulse |
| link_evt_i | input | 1 | Link state changed pulse |
| asc_evt_i | input | 1 | Alternate start code frame received pulse |
| ident_evt_i | input | 1 | Identify state changed pulse |
| ext_evt_i | input | EXT_W | Extended event pulses, bit 0 is request available |
| busy_i | input | 1 | Host interface cannot accept the current command |
| payload_rdy_i | input | 1 | Command engine waits for the payload transaction |
| xfer_done_i | input | 1 | Successful transaction finished |
| mask_wr_i | input | 1 | Primary enable register write strobe |
| mask_wdata_i | input | 8 | Primary enable write data |
| ext_mask_wr_i | input | 1 | Extended enable register write strobe |
| ext_mask_wdata_i | input | EXT_W | Extended enable write data |
| clr_data_rd_i | input | 1 | Bulk data read command completed |
| clr_status_rd_i | input | 1 | Status register read |
| clr_info_rd_i | input | 1 | Frame-information register read |
| clr_req_rd_i | input | 1 | Request read command completed |
| req_timeout_i | input | 1 | Pending request timed out |
| clr_ext_rd_i | input | 1 | Extended flags register read |
| flags_o | output | 8 | Flag byte |
| ext_flags_o | output | EXT_W | Extended flags word |
| mask_o | output | 8 | Primary enable register |
| ext_mask_o | output | EXT_W | Extended enable register |
| irq_n_o | output | 1 | Active-low interrupt pin |

## Verification
The bench aims at a set and a clear in the same cycle. A design with the wrong priority would drop an event that arrived during the read meant for the previous one. It drives `win_diff_i` without a completed frame, which a careless decode would latch as a window change. It also fires the extended-flags read while a request is pending. A shared clear would wrongly wipe that request. Finally, it fires the completion strobe while a flag is still pending. A pin without the forced high cycle would stay low and give the host no new falling edge.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    localparam int FLAG_W = 8;
    localparam int PRIM_W = 6;

    typedef enum logic [2:0] {
        FB_FRAME = 3'd0,
        FB_LOST  = 3'd1,
        FB_WCHG  = 3'd2,
        FB_LINK  = 3'd3,
        FB_ASC   = 3'd4,
        FB_IDENT = 3'd5,
        FB_EXT   = 3'd6,
        FB_BUSY  = 3'd7
    } flag_bit_e;

    typedef struct packed {
        logic frame_done;
        logic win_diff;
        logic lost;
        logic link;
        logic asc;
        logic ident;
    } evt_s;

    typedef struct packed {
        logic data_rd;
        logic status_rd;
        logic info_rd;
    } clr_s;

    localparam logic [FLAG_W-1:0] PRIM_MASK_WR = 8'h7F;

    function automatic logic [PRIM_W-1:0] prim_set(evt_s e);
        logic [PRIM_W-1:0] v;
        v = '0;
        v[int'(FB_FRAME)] = e.frame_done;
        v[int'(FB_LOST)]  = e.lost;
        v[int'(FB_WCHG)]  = e.frame_done & e.win_diff;
        v[int'(FB_LINK)]  = e.link;
        v[int'(FB_ASC)]   = e.asc;
        v[int'(FB_IDENT)] = e.ident;
        return v;
    endfunction

    function automatic logic [PRIM_W-1:0] prim_clr(clr_s c);
        logic [PRIM_W-1:0] v;
        v = '0;
        v[int'(FB_FRAME)] = c.data_rd;
        v[int'(FB_WCHG)]  = c.data_rd;
        v[int'(FB_LOST)]  = c.status_rd;
        v[int'(FB_LINK)]  = c.status_rd;
        v[int'(FB_IDENT)] = c.status_rd;
        v[int'(FB_ASC)]   = c.info_rd;
        return v;
    endfunction

endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);

    logic [W-1:0] flag_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_i[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

    assign flag_o = flag_q;

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((flag_q & $past(set_i)) == $past(set_i)));

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((flag_q & ~$past(flag_q) & ~$past(set_i)) == '0));

    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((flag_q & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int           W       = 8,
    parameter logic [W-1:0] WR_MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);

    logic [W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_i) begin
            mask_q <= wdata_i & WR_MASK;
        end
    end

    assign mask_o = mask_q;

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_i)) |-> (mask_q == $past(mask_q)));

    // R6
    mask_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q & ~WR_MASK) == '0);

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic want_i,
    input  logic xfer_done_i,
    output logic irq_n_o
);

    logic irq_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_n_q <= 1'b1;
        end else if (xfer_done_i) begin
            irq_n_q <= 1'b1;
        end else begin
            irq_n_q <= ~want_i;
        end
    end

    assign irq_n_o = irq_n_q;

    // R11
    holdoff_high_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done_i |=> irq_n_q);

    // R10
    pending_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!xfer_done_i && want_i) |=> !irq_n_q);

    // R10
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!xfer_done_i && !want_i) |=> irq_n_q);

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int EXT_W   = 8,
    parameter int REQ_BIT = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_done_i,
    input  logic             win_diff_i,
    input  logic             lost_evt_i,
    input  logic             link_evt_i,
    input  logic             asc_evt_i,
    input  logic             ident_evt_i,
    input  logic [EXT_W-1:0] ext_evt_i,
    input  logic             busy_i,
    input  logic             payload_rdy_i,
    input  logic             xfer_done_i,
    input  logic             mask_wr_i,
    input  logic [7:0]       mask_wdata_i,
    input  logic             ext_mask_wr_i,
    input  logic [EXT_W-1:0] ext_mask_wdata_i,
    input  logic             clr_data_rd_i,
    input  logic             clr_status_rd_i,
    input  logic             clr_info_rd_i,
    input  logic             clr_req_rd_i,
    input  logic             req_timeout_i,
    input  logic             clr_ext_rd_i,
    output logic [7:0]       flags_o,
    output logic [EXT_W-1:0] ext_flags_o,
    output logic [7:0]       mask_o,
    output logic [EXT_W-1:0] ext_mask_o,
    output logic             irq_n_o
);

    localparam int PIN_SRC_W = PRIM_W + 1;

    evt_s             evt;
    clr_s             clr;
    logic [PRIM_W-1:0] prim_flags;
    logic [EXT_W-1:0]  ext_clr;
    logic [EXT_W-1:0]  ext_flags;
    logic [FLAG_W-1:0] prim_mask;
    logic [EXT_W-1:0]  ext_mask;
    logic              ext_any;
    logic [PIN_SRC_W-1:0] pin_src;
    logic              want;

    always_comb begin
        evt.frame_done = frame_done_i;
        evt.win_diff   = win_diff_i;
        evt.lost       = lost_evt_i;
        evt.link       = link_evt_i;
        evt.asc        = asc_evt_i;
        evt.ident      = ident_evt_i;
        clr.data_rd    = clr_data_rd_i;
        clr.status_rd  = clr_status_rd_i;
        clr.info_rd    = clr_info_rd_i;
    end

    irq_sticky_bank #(.W(PRIM_W)) u_prim_bank (
        .clk    (clk),
        .rst    (rst),
        .set_i  (prim_set(evt)),
        .clr_i  (prim_clr(clr)),
        .flag_o (prim_flags)
    );

    for (genvar i = 0; i < EXT_W; i++) begin : g_ext_clr
        if (i == REQ_BIT) begin : g_req
            assign ext_clr[i] = clr_req_rd_i | req_timeout_i;
        end else begin : g_other
            assign ext_clr[i] = clr_ext_rd_i;
        end
    end

    irq_sticky_bank #(.W(EXT_W)) u_ext_bank (
        .clk    (clk),
        .rst    (rst),
        .set_i  (ext_evt_i),
        .clr_i  (ext_clr),
        .flag_o (ext_flags)
    );

    irq_mask_reg #(.W(FLAG_W), .WR_MASK(PRIM_MASK_WR)) u_prim_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (mask_wr_i),
        .wdata_i (mask_wdata_i),
        .mask_o  (prim_mask)
    );

    irq_mask_reg #(.W(EXT_W), .WR_MASK({EXT_W{1'b1}})) u_ext_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (ext_mask_wr_i),
        .wdata_i (ext_mask_wdata_i),
        .mask_o  (ext_mask)
    );

    assign ext_any = |(ext_flags & ext_mask);
    assign pin_src = {ext_any, prim_flags};
    assign want    = (|(pin_src & prim_mask[PIN_SRC_W-1:0])) | payload_rdy_i;

    irq_pin_ctrl u_pin (
        .clk         (clk),
        .rst         (rst),
        .want_i      (want),
        .xfer_done_i (xfer_done_i),
        .irq_n_o     (irq_n_o)
    );

    assign flags_o     = {busy_i, ext_any, prim_flags};
    assign ext_flags_o = ext_flags;
    assign mask_o      = prim_mask;
    assign ext_mask_o  = ext_mask;

    // R9
    busy_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        flags_o[int'(FB_BUSY)] == busy_i);

    // R3
    wchg_needs_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(flags_o[int'(FB_WCHG)]) && flags_o[int'(FB_WCHG)])
        |-> $past(frame_done_i && win_diff_i));

    // R8
    req_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_flags_o[REQ_BIT] && !clr_req_rd_i && !req_timeout_i) |=> ext_flags_o[REQ_BIT]);

endmodule

// File: tb/irq_flag_ctrl_tb_top.sv
module irq_flag_ctrl_tb_top;

    localparam int EXT_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_done = 0, win_diff = 0, lost_evt = 0, link_evt = 0, asc_evt = 0, ident_evt = 0;
    logic [EXT_W-1:0] ext_evt = '0;
    logic busy = 0, payload_rdy = 0, xfer_done = 0;
    logic mask_wr = 0;
    logic [7:0] mask_wd = '0;
    logic ext_mask_wr = 0;
    logic [EXT_W-1:0] ext_mask_wd = '0;
    logic data_rd = 0, status_rd = 0, info_rd = 0, req_rd = 0, req_to = 0, ext_rd = 0;

    logic [7:0]       flags_o;
    logic [EXT_W-1:0] ext_flags_o;
    logic [7:0]       mask_o;
    logic [EXT_W-1:0] ext_mask_o;
    logic             irq_n_o;

    logic [5:0]       m_f;
    logic [EXT_W-1:0] m_e;
    logic [7:0]       m_m;
    logic [EXT_W-1:0] m_em;
    logic             m_irqn;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    irq_flag_ctrl #(.EXT_W(EXT_W), .REQ_BIT(0)) dut_i (
        .clk(clk), .rst(rst),
        .frame_done_i(frame_done), .win_diff_i(win_diff), .lost_evt_i(lost_evt),
        .link_evt_i(link_evt), .asc_evt_i(asc_evt), .ident_evt_i(ident_evt),
        .ext_evt_i(ext_evt), .busy_i(busy), .payload_rdy_i(payload_rdy),
        .xfer_done_i(xfer_done), .mask_wr_i(mask_wr), .mask_wdata_i(mask_wd),
        .ext_mask_wr_i(ext_mask_wr), .ext_mask_wdata_i(ext_mask_wd),
        .clr_data_rd_i(data_rd), .clr_status_rd_i(status_rd), .clr_info_rd_i(info_rd),
        .clr_req_rd_i(req_rd), .req_timeout_i(req_to), .clr_ext_rd_i(ext_rd),
        .flags_o(flags_o), .ext_flags_o(ext_flags_o), .mask_o(mask_o),
        .ext_mask_o(ext_mask_o), .irq_n_o(irq_n_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [EXT_W-1:0] ext_clear_vec();
        logic [EXT_W-1:0] v;
        v = ext_rd ? '1 : '0;
        v[0] = req_rd | req_to;
        return v;
    endfunction

    task automatic clear_inputs();
        frame_done = 0; win_diff = 0; lost_evt = 0; link_evt = 0; asc_evt = 0; ident_evt = 0;
        ext_evt = '0; xfer_done = 0; mask_wr = 0; ext_mask_wr = 0;
        data_rd = 0; status_rd = 0; info_rd = 0; req_rd = 0; req_to = 0; ext_rd = 0;
    endtask

    task automatic tick(input string tag);
        logic [5:0] nf;
        logic agg, want;
        @(posedge clk);
        if (rst) begin
            m_f = '0; m_e = '0; m_m = '0; m_em = '0; m_irqn = 1'b1;
        end else begin
            agg  = |(m_e & m_em);
            want = (|({agg, m_f} & m_m[6:0])) | payload_rdy;
            nf[0] = (m_f[0] & ~data_rd)   | frame_done;
            nf[1] = (m_f[1] & ~status_rd) | lost_evt;
            nf[2] = (m_f[2] & ~data_rd)   | (frame_done & win_diff);
            nf[3] = (m_f[3] & ~status_rd) | link_evt;
            nf[4] = (m_f[4] & ~info_rd)   | asc_evt;
            nf[5] = (m_f[5] & ~status_rd) | ident_evt;
            m_e   = (m_e & ~ext_clear_vec()) | ext_evt;
            m_irqn = xfer_done ? 1'b1 : ~want;
            m_f = nf;
            if (mask_wr)     m_m  = mask_wd & 8'h7F;
            if (ext_mask_wr) m_em = ext_mask_wd;
        end
        @(negedge clk);
        chk({tag, " R2 R3 R4 R5 R7 R9 flag byte"}, 32'(flags_o), 32'({busy, |(m_e & m_em), m_f}));
        chk({tag, " R8 extended flags"}, 32'(ext_flags_o), 32'(m_e));
        chk({tag, " R6 primary enables"}, 32'(mask_o), 32'(m_m));
        chk({tag, " R6 extended enables"}, 32'(ext_mask_o), 32'(m_em));
        chk({tag, " R10 R11 pin"}, 32'(irq_n_o), 32'(m_irqn));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h1F2E3D4C));
        // R1 reset state
        rst = 1;
        tick("R1 reset");
        tick("R1 reset");
        @(negedge clk);
        rst = 0;
        tick("R1 after reset");

        // R3: window difference without a completed frame
        win_diff = 1;
        tick("R3 diff alone");
        clear_inputs();
        frame_done = 1;
        tick("R3 frame alone");
        clear_inputs();
        frame_done = 1; win_diff = 1;
        tick("R3 frame and diff");
        clear_inputs();
        // R10: enables at zero keep the pin high
        tick("R10 masked");
        // R6: bit 7 of the primary enable is not stored
        mask_wr = 1; mask_wd = 8'hFF;
        tick("R6 write");
        clear_inputs();
        tick("R10 enabled pending");
        // R5: new frame during its bulk read
        data_rd = 1; frame_done = 1;
        tick("R5 set wins");
        clear_inputs();
        // R11: completion strobe while still pending
        xfer_done = 1;
        tick("R11 holdoff");
        clear_inputs();
        tick("R11 refire");
        // R4 clears
        lost_evt = 1; link_evt = 1; ident_evt = 1; asc_evt = 1;
        tick("R4 set group");
        clear_inputs();
        status_rd = 1;
        tick("R4 status read");
        clear_inputs();
        info_rd = 1;
        tick("R4 info read");
        clear_inputs();
        data_rd = 1;
        tick("R4 data read");
        clear_inputs();
        // R8 and R7: extended word
        ext_evt = 8'h09; ext_mask_wr = 1; ext_mask_wd = 8'h08;
        tick("R7 ext set");
        clear_inputs();
        ext_rd = 1;
        tick("R8 ext read keeps request");
        clear_inputs();
        req_to = 1;
        tick("R8 timeout clears request");
        clear_inputs();
        ext_evt = 8'h01; req_rd = 1;
        tick("R8 request set wins");
        clear_inputs();
        req_rd = 1;
        tick("R8 request read");
        clear_inputs();
        // R9 busy and R10 payload handshake
        busy = 1;
        tick("R9 busy");
        busy = 0; payload_rdy = 1;
        tick("R10 payload ready");
        payload_rdy = 0;
        tick("R10 idle");

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            frame_done  = ($urandom % 6) == 0;
            win_diff    = ($urandom % 2) == 0;
            lost_evt    = ($urandom % 9) == 0;
            link_evt    = ($urandom % 9) == 0;
            asc_evt     = ($urandom % 9) == 0;
            ident_evt   = ($urandom % 9) == 0;
            ext_evt     = (($urandom % 5) == 0) ? EXT_W'($urandom) : '0;
            busy        = ($urandom % 7) == 0;
            payload_rdy = ($urandom % 10) == 0;
            xfer_done   = ($urandom % 6) == 0;
            mask_wr     = ($urandom % 25) == 0;
            mask_wd     = 8'($urandom);
            ext_mask_wr = ($urandom % 25) == 0;
            ext_mask_wd = EXT_W'($urandom);
            data_rd     = ($urandom % 5) == 0;
            status_rd   = ($urandom % 5) == 0;
            info_rd     = ($urandom % 5) == 0;
            req_rd      = ($urandom % 8) == 0;
            req_to      = ($urandom % 12) == 0;
            ext_rd      = ($urandom % 6) == 0;
            tick("random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule